// File: doc/BRIEF.md
# Message Interrupt Request Controller

This block sits between a set of on-chip peripheral interrupt lines and the application-side message interrupt port of a PCI Express endpoint core. A rising edge on any source line is remembered as a pending bit. While the host has message interrupts switched on and has granted the function bus mastering, the block picks one pending source in round-robin order. It raises a request to the core with the source's index encoded in the message number, then holds the request until the core acknowledges it.

The message number tells the interrupt handler which peripheral fired, so the handler does not have to read a status register first. When the host has granted fewer vectors than there are sources, the number is clipped to the highest vector granted. Pending bits are also visible as a status word, and software can clear them by writing ones.

Top module: `msi_req_ctrl`

## Requirements
- R1: A 0-to-1 transition on `src_irq[i]` sets pending bit i one clock later. A source held high sets nothing further after that bit is served.
- R2: A new request starts only while both `cfg_msi_en` and `cfg_bus_master` are 1. Pending bits are kept while either is 0, and requests resume once both are 1 again.
- R3: After source i is served, the next grant goes to the first pending index above i, wrapping from the top index back to 0. After reset the search starts at index 0.
- R4: `msi_num` equals the granted index when that index is below 2^m, and 2^m-1 otherwise. Here m is `cfg_mme`, with any value above 5 treated as 5.
- R5: From the cycle `msi_req` rises until the cycle `msi_ack` is seen, `msi_req` stays 1 and `msi_num` does not change.
- R6: The clock edge that samples `msi_ack` high during a request clears the served pending bit. It also drops `msi_req` for at least one cycle.
- R7: A source rising edge in the same cycle as the acknowledge of that same source leaves its pending bit set, and a new request for it follows.
- R8: `msi_tc` is always 0.
- R9: When `sw_clr_we` is 1, each 1 in `sw_clr_data` clears that pending bit and each 0 leaves its bit alone. A rising edge in the same cycle wins over the clear.
- R10: After reset, `msi_req` is 0 and `pend_status` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_irq | input | 16 | Peripheral interrupt lines, edge-sensitive |
| cfg_msi_en | input | 1 | Shadow of the message interrupt enable bit |
| cfg_bus_master | input | 1 | Shadow of the bus master enable bit |
| cfg_mme | input | 3 | Shadow of the granted-vector field, log2 of the vector count |
| sw_clr_we | input | 1 | Software write strobe for the pending status |
| sw_clr_data | input | 16 | Write-one-to-clear mask |
| pend_status | output | 16 | Pending bits, one per source |
| msi_req | output | 1 | Message interrupt request to the core |
| msi_ack | input | 1 | Acknowledge from the core |
| msi_num | output | 5 | Message number of the current request |
| msi_tc | output | 3 | Traffic class, held at 0 |

## Verification
Two pairs of functions can land on the same edge. The first pair is the acknowledge clearing a pending bit and a fresh rising edge on that same source setting it. The second pair is a software clear and a rising edge of the same bit. In the bench, the source goes low beforehand and is then raised in the very cycle that carries the acknowledge or the clear strobe. The result is judged at the ports: the status bit must remain set, and for the acknowledge case a second request carrying the same number must follow the one-cycle gap.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam int MSI_NUM_W = 5;
  localparam int MSI_MME_W = 3;
  localparam int MSI_MME_MAX = 5;

  // Clip a source index to the top granted vector (R4).
  function automatic logic [MSI_NUM_W-1:0] msg_num_clip(
    input logic [MSI_NUM_W-1:0] idx,
    input logic [MSI_MME_W-1:0] mme
  );
    logic [MSI_NUM_W:0]   vec_cnt;
    logic [MSI_NUM_W-1:0] top;
    int unsigned          m;
    m = (int'(mme) > MSI_MME_MAX) ? MSI_MME_MAX : int'(mme);
    vec_cnt = (MSI_NUM_W+1)'(1) << m;
    top = MSI_NUM_W'(vec_cnt - 1'b1);
    return (idx > top) ? top : idx;
  endfunction
endpackage

// File: rtl/msi_pend.sv
module msi_pend #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src,
  input  logic [N-1:0] clr_ack,
  input  logic [N-1:0] clr_sw,
  output logic [N-1:0] rise,
  output logic [N-1:0] pend
);
  logic [N-1:0] src_q;

  assign rise = src & ~src_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      pend  <= '0;
    end else begin
      src_q <= src;
      pend  <= (pend & ~(clr_ack | clr_sw)) | rise;
    end
  end

  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((pend & $past(rise)) == $past(rise))); // R1

  AST_CLR_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_ack & ~rise)) |=> ((pend & $past(clr_ack & ~rise)) == '0)); // R6
endmodule

// File: rtl/msi_rr_arb.sv
module msi_rr_arb #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  pend,
  input  logic [IW-1:0] ptr,
  output logic          vld,
  output logic [IW-1:0] idx
);
  always_comb begin
    vld = 1'b0;
    idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      int j;
      j = (int'(ptr) + k) % N;
      if (pend[j]) begin
        vld = 1'b1;
        idx = IW'(j);
      end
    end
  end

  AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> pend[idx]); // R3

  AST_GRANT_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend) |-> vld); // R3
endmodule

// File: rtl/msi_req_fsm.sv
module msi_req_fsm
  import msi_pkg::*;
#(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 gate,
  input  logic                 vld,
  input  logic [IW-1:0]        idx,
  input  logic [MSI_MME_W-1:0] mme,
  input  logic                 ack,
  output logic                 req,
  output logic [MSI_NUM_W-1:0] num,
  output logic [IW-1:0]        ptr,
  output logic [N-1:0]         ack_clr
);
  logic [IW-1:0] cur;
  logic          issue;
  logic          done;

  assign issue = !req && gate && vld;
  assign done  = req && ack;

  always_comb begin
    ack_clr = '0;
    if (done) ack_clr[cur] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req <= 1'b0;
      num <= '0;
      cur <= '0;
      ptr <= '0;
    end else if (issue) begin
      req <= 1'b1;
      cur <= idx;
      num <= msg_num_clip(MSI_NUM_W'(idx), mme);
    end else if (done) begin
      req <= 1'b0;
      ptr <= (cur == IW'(N - 1)) ? '0 : cur + 1'b1;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> (req && $stable(num))); // R5

  AST_ACK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ack) |=> !req); // R6

  AST_GATED_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> $past(gate)); // R2

  AST_ONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_clr)); // R6
endmodule

// File: rtl/msi_req_ctrl.sv
module msi_req_ctrl
  import msi_pkg::*;
#(
  parameter int NUM_SRC = 16,
  localparam int IW = $clog2(NUM_SRC)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   src_irq,
  input  logic                 cfg_msi_en,
  input  logic                 cfg_bus_master,
  input  logic [MSI_MME_W-1:0] cfg_mme,
  input  logic                 sw_clr_we,
  input  logic [NUM_SRC-1:0]   sw_clr_data,
  output logic [NUM_SRC-1:0]   pend_status,
  output logic                 msi_req,
  input  logic                 msi_ack,
  output logic [MSI_NUM_W-1:0] msi_num,
  output logic [2:0]           msi_tc
);
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] ack_clr;
  logic [NUM_SRC-1:0] sw_clr;
  logic [IW-1:0]      ptr;
  logic [IW-1:0]      win_idx;
  logic               win_vld;
  logic               gate;

  assign gate        = cfg_msi_en && cfg_bus_master;
  assign sw_clr      = sw_clr_we ? sw_clr_data : '0;
  assign pend_status = pend;
  assign msi_tc      = 3'd0;

  msi_pend #(.N(NUM_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .src(src_irq),
    .clr_ack(ack_clr), .clr_sw(sw_clr), .rise(rise), .pend(pend)
  );

  msi_rr_arb #(.N(NUM_SRC), .IW(IW)) u_arb (
    .clk(clk), .rst_n(rst_n), .pend(pend), .ptr(ptr),
    .vld(win_vld), .idx(win_idx)
  );

  msi_req_fsm #(.N(NUM_SRC), .IW(IW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .gate(gate), .vld(win_vld), .idx(win_idx),
    .mme(cfg_mme), .ack(msi_ack), .req(msi_req), .num(msi_num),
    .ptr(ptr), .ack_clr(ack_clr)
  );

  AST_SW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sw_clr & ~rise)) |=> ((pend_status & $past(sw_clr & ~rise & ~0)) == '0)); // R9
endmodule

// File: tb/sim_msi_req_ctrl.sv
module sim_msi_req_ctrl;
  localparam int N = 16;
  localparam int NV = 6;
  localparam logic [18:0] VEC [NV] = '{
    {16'h0001, 3'd5}, {16'h8001, 3'd5}, {16'h0121, 3'd4},
    {16'hC000, 3'd2}, {16'h00A4, 3'd0}, {16'h1234, 3'd3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] src_irq = '0;
  logic cfg_msi_en = 1'b0, cfg_bus_master = 1'b0;
  logic [2:0] cfg_mme = 3'd5;
  logic sw_clr_we = 1'b0;
  logic [N-1:0] sw_clr_data = '0;
  logic [N-1:0] pend_status;
  logic msi_req, msi_ack = 1'b0;
  logic [4:0] msi_num;
  logic [2:0] msi_tc;

  int n_chk = 0, n_bad = 0;
  int bptr = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  msi_req_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .cfg_msi_en(cfg_msi_en),
    .cfg_bus_master(cfg_bus_master), .cfg_mme(cfg_mme), .sw_clr_we(sw_clr_we),
    .sw_clr_data(sw_clr_data), .pend_status(pend_status), .msi_req(msi_req),
    .msi_ack(msi_ack), .msi_num(msi_num), .msi_tc(msi_tc)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_num(input int idx, input int mme);
    int lim = 1;
    int m = (mme > 5) ? 5 : mme;
    for (int k = 0; k < m; k++) lim = lim + lim;
    return (idx < lim) ? idx : lim - 1;
  endfunction

  function automatic int next_pick(input logic [N-1:0] mask, input int from);
    for (int k = 0; k < N; k++)
      if (mask[(from + k) % N]) return (from + k) % N;
    return -1;
  endfunction

  task automatic serve(input int idx);
    int num0;
    for (int w = 0; w < 20 && !msi_req; w++) tick();
    check(msi_req === 1'b1, "R2 request raised", int'(msi_req), 1);
    check(int'(msi_num) == exp_num(idx, int'(cfg_mme)), "R4/R3 message number",
          int'(msi_num), exp_num(idx, int'(cfg_mme)));
    num0 = int'(msi_num);
    tick();
    tick();
    check(msi_req === 1'b1 && int'(msi_num) == num0, "R5 held until ack",
          int'(msi_num), num0);
    msi_ack = 1'b1;
    tick();
    msi_ack = 1'b0;
    check(msi_req === 1'b0, "R6 gap after ack", int'(msi_req), 0);
    check(pend_status[idx] === 1'b0, "R6 pending cleared", int'(pend_status[idx]), 0);
    bptr = (idx + 1) % N;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] mask;
    int pick;
    @(negedge clk);
    tick();
    tick();
    rst_n = 1'b1;
    tick();
    // R10 and R8
    check(msi_req === 1'b0, "R10 reset request", int'(msi_req), 0);
    check(pend_status === '0, "R10 reset status", int'(pend_status), 0);
    check(msi_tc === 3'd0, "R8 traffic class", int'(msi_tc), 0);

    // R2: enable off keeps source pending, no request
    cfg_bus_master = 1'b1;
    src_irq[3] = 1'b1; tick(); src_irq[3] = 1'b0;
    for (int k = 0; k < 4; k++) tick();
    check(msi_req === 1'b0, "R2 gated by enable", int'(msi_req), 0);
    check(pend_status === 16'h0008, "R1 edge latched", int'(pend_status), 8);
    cfg_msi_en = 1'b1;
    serve(3);
    // R2: bus master off
    cfg_bus_master = 1'b0;
    src_irq[5] = 1'b1; tick(); src_irq[5] = 1'b0;
    for (int k = 0; k < 4; k++) tick();
    check(msi_req === 1'b0, "R2 gated by bus master", int'(msi_req), 0);
    cfg_bus_master = 1'b1;
    serve(5);

    // R9: write-one-to-clear
    cfg_msi_en = 1'b0;
    src_irq[7] = 1'b1; src_irq[9] = 1'b1; tick();
    src_irq[7] = 1'b0; src_irq[9] = 1'b0;
    sw_clr_we = 1'b1; sw_clr_data = 16'h0080; tick();
    check(pend_status === 16'h0200, "R9 one clears", int'(pend_status), 16'h0200);
    sw_clr_data = 16'h0000; tick();
    check(pend_status === 16'h0200, "R9 zero keeps", int'(pend_status), 16'h0200);
    sw_clr_data = 16'h0200; src_irq[9] = 1'b1; tick();
    sw_clr_we = 1'b0; sw_clr_data = '0; src_irq[9] = 1'b0;
    check(pend_status === 16'h0200, "R9 edge beats clear", int'(pend_status), 16'h0200);
    cfg_msi_en = 1'b1;
    serve(9);

    // R7: edge coinciding with acknowledge of the same source
    src_irq[2] = 1'b1; tick(); src_irq[2] = 1'b0;
    for (int w = 0; w < 20 && !msi_req; w++) tick();
    check(int'(msi_num) == 2, "R7 first request", int'(msi_num), 2);
    msi_ack = 1'b1; src_irq[2] = 1'b1; tick();
    msi_ack = 1'b0; src_irq[2] = 1'b0;
    bptr = 3;
    check(pend_status[2] === 1'b1, "R7 edge beats ack", int'(pend_status[2]), 1);
    serve(2);

    // table of source patterns and vector grants: R3, R4, R1
    for (int v = 0; v < NV; v++) begin
      mask = VEC[v][18:3];
      cfg_mme = VEC[v][2:0];
      src_irq = mask;
      tick();
      while (mask != '0) begin
        pick = next_pick(mask, bptr);
        serve(pick);
        mask[pick] = 1'b0;
      end
      for (int k = 0; k < 3; k++) tick();
      check(msi_req === 1'b0 && pend_status === '0, "R1 held level no retrigger",
            int'(pend_status), 0);
      src_irq = '0;
      tick();
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule